// File: doc/BRIEF.md
# Latency-Based Pipeline Interlock Unit

This block lives in the decode stage of an in-order pipeline that forwards every result and whose floating-point units are fully pipelined. Each cycle it looks at the instruction held in decode, compares that instruction's source registers against the producers issued in the recent past, and decides whether the instruction may issue now or must wait. The waiting time depends on the pair of instruction classes involved (who produced the value, and how the consumer uses it), not on a single load-use rule.

Every architectural register name owns a small countdown and the class of its most recent producer. When a producer issues, its destination countdown is loaded with the longest separation that class can ever demand; it then falls by one each clock, whether or not decode is stalled. A consumer compares the countdown against the separation its own class needs and holds decode while the remaining count is too large. A branch, resolved in decode, also blocks the slot right after it. Register names form one flat space; the bench places floating-point and integer values in disjoint names.

Top module: `pipe_interlock`

## Requirements
- R1: The class input uses the encoding 0 = none, 1 = floating-point arithmetic, 2 = double load, 3 = double store, 4 = integer arithmetic, 5 = branch, 6 and 7 = none. `issue` is high exactly when `dec_valid` is high and `stall` is low. With `dec_valid` low, `stall` and `issue` are both low. A class-0 instruction never stalls.
- R2: A floating-point arithmetic consumer that reads the destination of a floating-point arithmetic producer issues no earlier than 4 cycles after that producer issues, that is 3 stall cycles when it follows immediately. Either source (a or b) triggers the check.
- R3: A store whose data source (b) is the destination of a floating-point arithmetic producer waits 2 stall cycles when it follows immediately.
- R4: A floating-point arithmetic consumer of a double load's destination waits 1 stall cycle when it follows immediately.
- R5: A store whose data source (b) is a double load's destination issues with no stall.
- R6: A branch that reads an integer arithmetic result waits 1 stall cycle when it follows immediately. An integer arithmetic consumer, or the address source (a) of a load or store, takes no stall on an integer result.
- R7: After a branch issues, the next cycle never issues: an instruction that follows immediately waits exactly 1 cycle. A decode slot left empty during that cycle absorbs the penalty.
- R8: Instructions that share no register names issue in consecutive cycles with no stall, whatever their classes.
- R9: A synchronous reset clears every countdown and any pending branch penalty, so the first instruction after reset issues at once even if it reads the destination of a producer issued just before reset.
- R10: Countdowns fall once per clock regardless of stalls, so cycles spent issuing unrelated instructions or idling count toward the required separation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_class | input | 3 | Class of the decode instruction (encoding in R1) |
| dec_dst | input | REG_BITS | Destination register name, used by classes 1, 2 and 4 |
| dec_src_a | input | REG_BITS | Source a; address source for loads and stores |
| dec_src_b | input | REG_BITS | Source b; data source for stores, used by classes 1, 3, 4 and 5 |
| stall | output | 1 | Decode must hold this cycle |
| issue | output | 1 | Decode instruction leaves this cycle |

## Verification
The bench builds the block with its default parameters: 32 register names and the separations 3, 2, 1, 0 and 1 for the five class pairs. With those values every nonzero separation ends within four cycles, so each producer-consumer pair can be driven back to back and the exact number of stall cycles compared against the table, along with gaps filled by unrelated instructions or idle slots, a branch followed by a dependent or independent instruction, and a reset arriving while a countdown is still live.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int REG_BITS   = 5,
  parameter int LAT_FP_FP  = 3,
  parameter int LAT_FP_ST  = 2,
  parameter int LAT_LD_FP  = 1,
  parameter int LAT_LD_ST  = 0,
  parameter int LAT_INT_BR = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dec_valid,
  input  logic [2:0]          dec_class,
  input  logic [REG_BITS-1:0] dec_dst,
  input  logic [REG_BITS-1:0] dec_src_a,
  input  logic [REG_BITS-1:0] dec_src_b,
  output logic                stall,
  output logic                issue
);

  localparam int NREG    = 1 << REG_BITS;
  localparam int MAX_FP  = (LAT_FP_FP > LAT_FP_ST) ? LAT_FP_FP : LAT_FP_ST;
  localparam int MAX_LD  = (LAT_LD_FP > LAT_LD_ST) ? LAT_LD_FP : LAT_LD_ST;
  localparam int MAX_INT = LAT_INT_BR;
  localparam int TOP_A   = (MAX_FP > MAX_LD) ? MAX_FP : MAX_LD;
  localparam int TOP     = (TOP_A > MAX_INT) ? TOP_A : MAX_INT;
  localparam int CW      = $clog2(TOP + 2);

  localparam logic [2:0] C_NONE = 3'd0;
  localparam logic [2:0] C_FP   = 3'd1;
  localparam logic [2:0] C_LD   = 3'd2;
  localparam logic [2:0] C_ST   = 3'd3;
  localparam logic [2:0] C_INT  = 3'd4;
  localparam logic [2:0] C_BR   = 3'd5;

  logic [CW-1:0] cnt_q [NREG];
  logic [2:0]    cls_q [NREG];
  logic          br_q;

  function automatic logic [CW-1:0] hold_of(input logic [2:0] p);
    case (p)
      C_FP:    hold_of = CW'(MAX_FP);
      C_LD:    hold_of = CW'(MAX_LD);
      C_INT:   hold_of = CW'(MAX_INT);
      default: hold_of = '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] need_of(input logic [2:0] p, input logic [2:0] c);
    need_of = '0;
    case (p)
      C_FP:  if (c == C_FP) need_of = CW'(LAT_FP_FP);
             else if (c == C_ST) need_of = CW'(LAT_FP_ST);
      C_LD:  if (c == C_FP) need_of = CW'(LAT_LD_FP);
             else if (c == C_ST) need_of = CW'(LAT_LD_ST);
      C_INT: if (c == C_BR) need_of = CW'(LAT_INT_BR);
      default: need_of = '0;
    endcase
  endfunction

  logic       known, use_a, use_b, writes;
  logic [2:0] role_a;
  logic       haz_a, haz_b;

  assign known  = (dec_class >= C_FP) && (dec_class <= C_BR);
  assign use_a  = known;
  assign use_b  = (dec_class == C_FP) || (dec_class == C_ST) ||
                  (dec_class == C_INT) || (dec_class == C_BR);
  assign writes = (dec_class == C_FP) || (dec_class == C_LD) || (dec_class == C_INT);
  assign role_a = (dec_class == C_LD || dec_class == C_ST) ? C_INT : dec_class;

  assign haz_a = use_a && (cnt_q[dec_src_a] >
                 (hold_of(cls_q[dec_src_a]) - need_of(cls_q[dec_src_a], role_a)));
  assign haz_b = use_b && (cnt_q[dec_src_b] >
                 (hold_of(cls_q[dec_src_b]) - need_of(cls_q[dec_src_b], dec_class)));

  assign stall = dec_valid && (br_q || haz_a || haz_b);
  assign issue = dec_valid && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        cnt_q[i] <= '0;
        cls_q[i] <= C_NONE;
      end
      br_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (issue && writes && dec_dst == REG_BITS'(i)) begin
          cnt_q[i] <= hold_of(dec_class);
          cls_q[i] <= dec_class;
        end else if (cnt_q[i] != '0) begin
          cnt_q[i] <= cnt_q[i] - CW'(1);
        end
      end
      br_q <= issue && (dec_class == C_BR);
    end
  end

  p_fp_fp_r2: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == C_FP) |=>
      !(issue && dec_class == C_FP &&
        (dec_src_a == $past(dec_dst) || dec_src_b == $past(dec_dst))));

  p_fp_st_r3: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == C_FP) |=>
      !(issue && dec_class == C_ST && dec_src_b == $past(dec_dst)));

  p_ld_fp_r4: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == C_LD) |=>
      !(issue && dec_class == C_FP &&
        (dec_src_a == $past(dec_dst) || dec_src_b == $past(dec_dst))));

  p_int_br_r6: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == C_INT) |=>
      !(issue && dec_class == C_BR &&
        (dec_src_a == $past(dec_dst) || dec_src_b == $past(dec_dst))));

  p_br_penalty_r7: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == C_BR) |=> !issue);

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_countdown_r10: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[g] != '0 && !(issue && writes && dec_dst == REG_BITS'(g))) |=>
        (cnt_q[g] == $past(cnt_q[g]) - CW'(1)));
  end

endmodule

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic [2:0] dec_class = 3'd0;
  logic [4:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic       stall, issue;

  int checks = 0, fails = 0;
  bit hung = 1'b0;

  localparam logic [2:0] NONE = 3'd0, FP = 3'd1, LD = 3'd2, ST = 3'd3, INTO = 3'd4, BR = 3'd5;

  always #10 clk = ~clk;

  pipe_interlock u_pipe_interlock (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .stall(stall), .issue(issue)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [4:0] d, input logic [4:0] a,
                      input logic [4:0] b, output int n);
    n = 0;
    @(negedge clk);
    dec_class = c; dec_dst = d; dec_src_a = a; dec_src_b = b; dec_valid = 1'b1;
    forever begin
      #2;
      if (issue) break;
      n++;
      if (n > 40) begin hung = 1'b1; break; end
      @(negedge clk);
    end
    @(posedge clk);
    #1 dec_valid = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(posedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(3);
    @(negedge clk);
    chk("R9 stall in reset", stall, 0);
    chk("R1 issue with no valid", issue, 0);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R1 idle stall", stall, 0);
    chk("R1 idle issue", issue, 0);
  endtask

  task automatic t_none;
    int n;
    send(NONE, 5'd1, 5'd1, 5'd1, n);
    chk("R1 class none", n, 0);
    send(3'd7, 5'd1, 5'd1, 5'd1, n);
    chk("R1 class 7", n, 0);
  endtask

  task automatic t_fp_fp;
    int n;
    send(FP, 5'd1, 5'd2, 5'd3, n);
    send(FP, 5'd4, 5'd1, 5'd5, n);
    chk("R2 fp to fp via a", n, 3);
    send(FP, 5'd6, 5'd7, 5'd4, n);
    chk("R2 fp to fp via b", n, 3);
    idle(5);
  endtask

  task automatic t_fp_st;
    int n;
    send(FP, 5'd8, 5'd2, 5'd3, n);
    send(ST, 5'd0, 5'd20, 5'd8, n);
    chk("R3 fp to store data", n, 2);
    idle(5);
  endtask

  task automatic t_ld;
    int n;
    send(LD, 5'd9, 5'd21, 5'd0, n);
    send(FP, 5'd10, 5'd9, 5'd2, n);
    chk("R4 load to fp", n, 1);
    idle(5);
    send(LD, 5'd11, 5'd21, 5'd0, n);
    send(ST, 5'd0, 5'd21, 5'd11, n);
    chk("R5 load to store data", n, 0);
    idle(5);
  endtask

  task automatic t_int;
    int n;
    send(INTO, 5'd22, 5'd23, 5'd24, n);
    send(BR, 5'd0, 5'd22, 5'd0, n);
    chk("R6 int to branch", n, 1);
    send(INTO, 5'd25, 5'd26, 5'd26, n);
    chk("R7 after branch", n, 1);
    send(INTO, 5'd27, 5'd25, 5'd26, n);
    chk("R6 int to int", n, 0);
    send(LD, 5'd12, 5'd27, 5'd0, n);
    chk("R6 int to load address", n, 0);
    idle(5);
  endtask

  task automatic t_branch;
    int n;
    send(BR, 5'd0, 5'd28, 5'd29, n);
    chk("R7 branch independent", n, 0);
    send(FP, 5'd13, 5'd2, 5'd3, n);
    chk("R7 independent after branch", n, 1);
    idle(4);
    send(BR, 5'd0, 5'd28, 5'd29, n);
    idle(1);
    send(FP, 5'd14, 5'd2, 5'd3, n);
    chk("R7 idle absorbs penalty", n, 0);
    idle(5);
  endtask

  task automatic t_indep;
    int n, tot;
    tot = 0;
    send(FP, 5'd15, 5'd2, 5'd3, n);   tot += n;
    send(FP, 5'd16, 5'd2, 5'd3, n);   tot += n;
    send(LD, 5'd17, 5'd21, 5'd0, n);  tot += n;
    send(INTO, 5'd30, 5'd23, 5'd24, n); tot += n;
    send(ST, 5'd0, 5'd21, 5'd2, n);   tot += n;
    chk("R8 independent stream", tot, 0);
    idle(5);
  endtask

  task automatic t_gap;
    int n;
    send(FP, 5'd18, 5'd2, 5'd3, n);
    send(INTO, 5'd31, 5'd23, 5'd24, n);
    send(FP, 5'd19, 5'd18, 5'd2, n);
    chk("R10 one filler", n, 2);
    send(FP, 5'd18, 5'd2, 5'd3, n);
    idle(2);
    send(FP, 5'd19, 5'd18, 5'd2, n);
    chk("R10 idle gap", n, 1);
    send(FP, 5'd18, 5'd2, 5'd3, n);
    idle(4);
    send(FP, 5'd19, 5'd18, 5'd2, n);
    chk("R10 long gap", n, 0);
    idle(5);
  endtask

  task automatic t_mid_reset;
    int n;
    send(FP, 5'd20, 5'd2, 5'd3, n);
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    send(FP, 5'd21, 5'd20, 5'd2, n);
    chk("R9 reset clears countdown", n, 0);
    idle(5);
    send(BR, 5'd0, 5'd28, 5'd29, n);
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    send(INTO, 5'd26, 5'd23, 5'd24, n);
    chk("R9 reset clears branch penalty", n, 0);
    idle(5);
  endtask

  initial begin
    t_reset();
    t_none();
    t_fp_fp();
    t_fp_st();
    t_ld();
    t_int();
    t_branch();
    t_indep();
    t_gap();
    t_mid_reset();
    if (hung) chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule